// File: doc/BRIEF.md
# Interrupt Cause Collector and Signaller

The block gathers interrupt causes into a sticky status word and turns them into an interrupt towards the host. A cause is set either by a one-cycle pulse from an internal source or by a software write to the raise register. Causes are removed only by a software write to the acknowledge register. Bits stay set until they are acknowledged.

Delivery depends on `msi_en`. With it low, the block drives a level line. With it high, the block emits a one-cycle message pulse for the message transport, which sits outside this block.

The two paths follow different rules:
- **Message pulse.** Every raise event that leaves the status nonzero produces a fresh pulse, even when the bits were already set.
- **Level line.** The line is deasserted only by an acknowledge that empties the status while message mode is off.

The line is held by a two-state machine:
- **LN_LOW → LN_HIGH (transition ASSERT):** a raise event that leaves the status nonzero, with message mode off.
- **LN_HIGH → LN_LOW (transition RELEASE):** an acknowledge write that leaves the status zero, with message mode off.
- **Otherwise:** the state holds.

The message pulse is a separate register, set for one cycle after each qualifying raise.

Top module: `irq_signal_unit`

## Requirements
- R1: After reset the status is zero, `irq_line` is low and `msi_pulse` is low.
- R2: A read with `reg_addr` = 0x24 returns the status word on `reg_rdata` combinationally. Any other address reads all ones.
- R3: A write to address 0x60 ORs `reg_wdata` into the status. The new value is visible from the following cycle.
- R4: A write to address 0x64 clears every status bit that is set in `reg_wdata`. Other bits are left unchanged.
- R5: With default parameters, a pulse on `src_pulse[0]` sets status bit 0 (compute done, 0x1), and a pulse on `src_pulse[1]` sets bit 8 (transfer done, 0x100).
- R6: With `msi_en` low, a raise event that leaves the status nonzero drives `irq_line` high from the next cycle.
- R7: `irq_line` falls only in the cycle after an acknowledge write that leaves the status zero while `msi_en` is low. An acknowledge that leaves bits set keeps the line high.
- R8: With `msi_en` high, every raise event that leaves the status nonzero gives exactly one cycle of `msi_pulse` in the next cycle. This holds even when the bits were already set, and includes a raise write of zero. The line is not asserted in this mode.
- R9: While `msi_en` is high, an acknowledge that empties the status does not deassert a line that was raised earlier in level mode.
- R10: Source pulses and a raise write in the same cycle are merged by OR into one raise event.
- R11: A raise and an acknowledge in the same cycle apply the raise first and then the clear. The line and pulse decisions use the resulting value, so a cause cleared in its own cycle signals nothing.
- R12: A raise event whose result is a zero status neither asserts the line nor emits a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_en | input | 1 | Selects message delivery (1) or level line (0) |
| src_pulse | input | NUM_SRC | One-cycle cause pulses from internal sources |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | STAT_W | Write data (mask) |
| reg_rdata | output | STAT_W | Read data for `reg_addr` |
| irq_line | output | 1 | Level interrupt line |
| msi_pulse | output | 1 | One-cycle message request |

## Verification
The bench builds the block with its defaults: a 32-bit status, an 8-bit address and two sources placed at bits 0 and 8. These defaults put both named causes, the full-width mask writes and the OR merge of the two sources with a software raise within reach of directed scenarios. With a single register bus, the raise-then-clear case is reached by pairing a source pulse with an acknowledge write in the same cycle, in both delivery modes. A mode switch in the middle of a scenario exposes the line left high while message mode is on.

// File: rtl/irq_sig_pkg.sv
package irq_sig_pkg;

    // Level-line holding state
    typedef enum logic [0:0] {
        LN_LOW  = 1'b0,
        LN_HIGH = 1'b1
    } line_state_e;

    // Field width used to place each source inside the status word
    localparam int SRC_POS_W = 8;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_sig_pkg::*;
#(
    parameter int                        STAT_W     = 32,
    parameter int                        ADDR_W     = 8,
    parameter int                        NUM_SRC    = 2,
    parameter logic [NUM_SRC*SRC_POS_W-1:0] SRC_POS = 16'h0800,
    parameter logic [ADDR_W-1:0]         OFF_STATUS = 8'h24,
    parameter logic [ADDR_W-1:0]         OFF_RAISE  = 8'h60,
    parameter logic [ADDR_W-1:0]         OFF_LOWER  = 8'h64
) (
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [STAT_W-1:0]  reg_wdata,
    input  logic [STAT_W-1:0]  status,
    output logic [STAT_W-1:0]  raise_mask,
    output logic [STAT_W-1:0]  lower_mask,
    output logic               raise_evt,
    output logic               lower_evt,
    output logic [STAT_W-1:0]  reg_rdata
);

    localparam logic [STAT_W-1:0] ONE  = {{(STAT_W-1){1'b0}}, 1'b1};
    localparam logic [STAT_W-1:0] ONES = {STAT_W{1'b1}};

    logic [STAT_W-1:0] src_bit [NUM_SRC];
    logic [STAT_W-1:0] hw_mask;
    logic              sw_raise;
    logic              sw_lower;

    // One placed bit per hardware source
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            assign src_bit[g] = src_pulse[g]
                              ? (ONE << SRC_POS[g*SRC_POS_W +: SRC_POS_W])
                              : '0;
        end
    endgenerate

    always_comb begin
        hw_mask = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            hw_mask = hw_mask | src_bit[i];
        end
    end

    assign sw_raise = reg_wr_en && (reg_addr == OFF_RAISE);
    assign sw_lower = reg_wr_en && (reg_addr == OFF_LOWER);

    // Hardware and software raises are merged before evaluation
    assign raise_mask = hw_mask | (sw_raise ? reg_wdata : '0);
    assign lower_mask = sw_lower ? reg_wdata : '0;
    assign raise_evt  = sw_raise || (|src_pulse);
    assign lower_evt  = sw_lower;

    assign reg_rdata = (reg_addr == OFF_STATUS) ? status : ONES;

endmodule

// File: rtl/irq_status_store.sv
module irq_status_store #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] raise_mask,
    input  logic [STAT_W-1:0] lower_mask,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] status_next
);

    // Raise applies first, then the clear
    assign status_next = (status | raise_mask) & ~lower_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= status_next;
        end
    end

    // R3 / R10: every raised bit not cleared in the same cycle is present afterwards
    assert_raise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_mask != '0) |=>
        ((status & ($past(raise_mask) & ~$past(lower_mask)))
            == ($past(raise_mask) & ~$past(lower_mask))));

    // R4: acknowledged bits are gone in the following cycle
    assert_lower_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lower_mask != '0) |=> ((status & $past(lower_mask)) == '0));

    // Sticky: no bit disappears without an acknowledge (R4)
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lower_mask == '0) |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/irq_delivery.sv
module irq_delivery
    import irq_sig_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_en,
    input  logic              raise_evt,
    input  logic              lower_evt,
    input  logic [STAT_W-1:0] status_next,
    input  logic [STAT_W-1:0] status,
    output logic              irq_line,
    output logic              msi_pulse
);

    line_state_e state_q;
    line_state_e state_d;
    logic        nz_next;
    logic        pulse_d;

    assign nz_next = |status_next;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_LOW: begin
                if (raise_evt && nz_next && !msi_en) begin
                    state_d = LN_HIGH;      // ASSERT
                end
            end
            LN_HIGH: begin
                if (lower_evt && !nz_next && !msi_en) begin
                    state_d = LN_LOW;       // RELEASE
                end
            end
            default: state_d = LN_LOW;
        endcase
    end

    assign pulse_d = raise_evt && nz_next && msi_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= LN_LOW;
            msi_pulse <= 1'b0;
        end else begin
            state_q   <= state_d;
            msi_pulse <= pulse_d;
        end
    end

    // Outputs
    always_comb begin
        irq_line = (state_q == LN_HIGH);
    end

    // R6: the line only rises with a nonzero status
    assert_line_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_line) |-> (status != '0));

    // R7: the line only falls with an empty status and level mode selected
    assert_line_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_line) |-> ((status == '0) && !$past(msi_en) && $past(lower_evt)));

    // R8: a pulse follows a raise in message mode and finds a nonzero status
    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> ($past(msi_en) && $past(raise_evt) && (status != '0)));

    // R12: a raise that leaves nothing set produces no pulse
    assert_no_empty_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_evt && (status_next == '0)) |=> !msi_pulse);

endmodule

// File: rtl/irq_signal_unit.sv
module irq_signal_unit
    import irq_sig_pkg::*;
#(
    parameter int                           STAT_W     = 32,
    parameter int                           ADDR_W     = 8,
    parameter int                           NUM_SRC    = 2,
    parameter logic [NUM_SRC*SRC_POS_W-1:0] SRC_POS    = 16'h0800,
    parameter logic [ADDR_W-1:0]            OFF_STATUS = 8'h24,
    parameter logic [ADDR_W-1:0]            OFF_RAISE  = 8'h60,
    parameter logic [ADDR_W-1:0]            OFF_LOWER  = 8'h64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msi_en,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [STAT_W-1:0]  reg_wdata,
    output logic [STAT_W-1:0]  reg_rdata,
    output logic               irq_line,
    output logic               msi_pulse
);

    logic [STAT_W-1:0] raise_mask;
    logic [STAT_W-1:0] lower_mask;
    logic              raise_evt;
    logic              lower_evt;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] status_next;

    irq_reg_decode #(
        .STAT_W     (STAT_W),
        .ADDR_W     (ADDR_W),
        .NUM_SRC    (NUM_SRC),
        .SRC_POS    (SRC_POS),
        .OFF_STATUS (OFF_STATUS),
        .OFF_RAISE  (OFF_RAISE),
        .OFF_LOWER  (OFF_LOWER)
    ) u_decode (
        .src_pulse  (src_pulse),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .status     (status),
        .raise_mask (raise_mask),
        .lower_mask (lower_mask),
        .raise_evt  (raise_evt),
        .lower_evt  (lower_evt),
        .reg_rdata  (reg_rdata)
    );

    irq_status_store #(
        .STAT_W (STAT_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise_mask  (raise_mask),
        .lower_mask  (lower_mask),
        .status      (status),
        .status_next (status_next)
    );

    irq_delivery #(
        .STAT_W (STAT_W)
    ) u_deliver (
        .clk         (clk),
        .rst_n       (rst_n),
        .msi_en      (msi_en),
        .raise_evt   (raise_evt),
        .lower_evt   (lower_evt),
        .status_next (status_next),
        .status      (status),
        .irq_line    (irq_line),
        .msi_pulse   (msi_pulse)
    );

endmodule

// File: tb/sim_irq_signal_unit.sv
`timescale 1ns/100ps
module sim_irq_signal_unit;

    localparam int STAT_W = 32;
    localparam int ADDR_W = 8;
    localparam int NUM_SRC = 2;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h24;
    localparam logic [ADDR_W-1:0] A_RAISE = 8'h60;
    localparam logic [ADDR_W-1:0] A_LOWER = 8'h64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               msi_en = 1'b0;
    logic [NUM_SRC-1:0] src_pulse = '0;
    logic               reg_wr_en = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [STAT_W-1:0]  reg_wdata = '0;
    logic [STAT_W-1:0]  reg_rdata;
    logic               irq_line;
    logic               msi_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_signal_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .msi_en    (msi_en),
        .src_pulse (src_pulse),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_line  (irq_line),
        .msi_pulse (msi_pulse)
    );

    task automatic chk(input string tag, input logic [STAT_W-1:0] act, input logic [STAT_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a negedge; return at the next negedge with inputs idle
    task automatic cyc(input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [STAT_W-1:0] d, input logic [NUM_SRC-1:0] s);
        reg_wr_en = wr; reg_addr = a; reg_wdata = d; src_pulse = s;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = A_STAT; reg_wdata = '0; src_pulse = '0;
    endtask

    task automatic rd_stat(input string tag, input logic [STAT_W-1:0] exp);
        reg_addr = A_STAT;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic out_chk(input string tag, input logic ln, input logic pl);
        chk({tag, " line"}, {31'd0, irq_line}, {31'd0, ln});
        chk({tag, " pulse"}, {31'd0, msi_pulse}, {31'd0, pl});
    endtask

    task automatic t_reset;
        rd_stat("R1 status", '0);
        out_chk("R1", 1'b0, 1'b0);
        reg_addr = 8'h00; #0.5;
        chk("R2 unmapped 00", reg_rdata, '1);
        reg_addr = A_RAISE; #0.5;
        chk("R2 unmapped raise", reg_rdata, '1);
        reg_addr = A_STAT;
    endtask

    task automatic t_level_sw;
        msi_en = 1'b0;
        cyc(1'b0, A_RAISE, 32'h0, 2'b00);
        cyc(1'b1, A_RAISE, 32'h0, 2'b00);
        rd_stat("R12 zero raise", '0);
        out_chk("R12 level", 1'b0, 1'b0);
        cyc(1'b1, A_RAISE, 32'h12, 2'b00);
        rd_stat("R3 raise", 32'h12);
        out_chk("R6", 1'b1, 1'b0);
        cyc(1'b1, A_RAISE, 32'h100, 2'b00);
        rd_stat("R3 or", 32'h112);
        cyc(1'b1, A_LOWER, 32'h10, 2'b00);
        rd_stat("R4 partial", 32'h102);
        out_chk("R7 keep", 1'b1, 1'b0);
        cyc(1'b1, A_LOWER, 32'h102, 2'b00);
        rd_stat("R4 all", '0);
        out_chk("R7 drop", 1'b0, 1'b0);
    endtask

    task automatic t_sources;
        msi_en = 1'b0;
        cyc(1'b0, A_STAT, '0, 2'b01);
        rd_stat("R5 src0", 32'h1);
        out_chk("R6 src", 1'b1, 1'b0);
        cyc(1'b0, A_STAT, '0, 2'b10);
        rd_stat("R5 src1", 32'h101);
        cyc(1'b1, A_LOWER, 32'hFFFF_FFFF, 2'b00);
        rd_stat("R4 clear", '0);
        out_chk("R7 src drop", 1'b0, 1'b0);
    endtask

    task automatic t_merge;
        msi_en = 1'b0;
        cyc(1'b1, A_RAISE, 32'h40, 2'b11);
        rd_stat("R10 merge", 32'h141);
        out_chk("R10", 1'b1, 1'b0);
        cyc(1'b1, A_LOWER, 32'h141, 2'b00);
        out_chk("R7 merge drop", 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle;
        msi_en = 1'b0;
        cyc(1'b1, A_LOWER, 32'h100, 2'b10);
        rd_stat("R11 level", '0);
        out_chk("R11 level", 1'b0, 1'b0);
        msi_en = 1'b1;
        cyc(1'b1, A_LOWER, 32'h1, 2'b11);
        rd_stat("R11 msi", 32'h100);
        out_chk("R11 msi", 1'b0, 1'b1);
        cyc(1'b1, A_LOWER, 32'h100, 2'b01);
        rd_stat("R11 msi2", 32'h1);
        cyc(1'b1, A_LOWER, 32'h1, 2'b00);
        rd_stat("R11 clear", '0);
        msi_en = 1'b0;
    endtask

    task automatic t_msi;
        msi_en = 1'b1;
        cyc(1'b1, A_RAISE, 32'h4, 2'b00);
        out_chk("R8 first", 1'b0, 1'b1);
        cyc(1'b0, A_STAT, '0, 2'b00);
        out_chk("R8 single", 1'b0, 1'b0);
        cyc(1'b1, A_RAISE, 32'h4, 2'b00);
        out_chk("R8 repeat", 1'b0, 1'b1);
        cyc(1'b1, A_RAISE, 32'h0, 2'b00);
        out_chk("R8 zero write", 1'b0, 1'b1);
        cyc(1'b1, A_LOWER, 32'h4, 2'b00);
        rd_stat("R4 msi", '0);
        out_chk("R8 lower", 1'b0, 1'b0);
        cyc(1'b1, A_RAISE, 32'h0, 2'b00);
        out_chk("R12 msi", 1'b0, 1'b0);
        msi_en = 1'b0;
    endtask

    task automatic t_msi_hold;
        msi_en = 1'b0;
        cyc(1'b1, A_RAISE, 32'h1, 2'b00);
        out_chk("R6 pre", 1'b1, 1'b0);
        msi_en = 1'b1;
        cyc(1'b1, A_LOWER, 32'h1, 2'b00);
        rd_stat("R9 status", '0);
        out_chk("R9 hold", 1'b1, 1'b0);
        msi_en = 1'b0;
        cyc(1'b0, A_STAT, '0, 2'b00);
        out_chk("R7 no ack", 1'b1, 1'b0);
        cyc(1'b1, A_LOWER, 32'h0, 2'b00);
        out_chk("R7 late drop", 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        reg_addr = A_STAT;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_level_sw;
        t_sources;
        t_merge;
        t_same_cycle;
        t_msi;
        t_msi_hold;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule